// File: doc/BRIEF.md
# TRB ring consumer fetch engine

This block is the consumer side of a producer/consumer ring of 16-byte transfer request blocks (TRBs) kept in system memory. Software first programs a 64-bit ring control register with a 64-byte-aligned ring pointer and the starting consumer cycle state. A doorbell pulse then starts the engine. It reads one 128-bit TRB at a time over a request/response memory port. It compares the TRB's cycle bit with its own cycle state to decide whether the producer has handed that entry over. Entries that it owns go out on a valid/ready stream, each marked when it closes a transfer descriptor.

Segments of the ring are joined by Link TRBs. The engine follows a link without presenting it on the stream, and inverts its cycle state when the link asks for that. The first entry whose cycle bit does not match means the ring is empty at that point. The engine then goes idle and keeps its place until the next doorbell. Software can stop the ring gently with pause, which takes effect after the next handoff, or at once with abort.

The controller is one state machine with five states:
- IDLE: not running.
- REQ: read request outstanding on the request side.
- WAIT: waiting for the read data.
- PRESENT: an owned TRB is held on the output.
- FLUSH: an aborted read whose response must still be absorbed.

Its transitions are:
- IDLE→REQ on a doorbell.
- REQ→WAIT when the request is accepted.
- REQ→FLUSH on an abort in the cycle the request is accepted, or REQ→IDLE on an abort without acceptance.
- WAIT→IDLE on a cycle mismatch.
- WAIT→REQ when a link is followed.
- WAIT→PRESENT when an owned entry arrives.
- WAIT→FLUSH or WAIT→IDLE on an abort, depending on whether the response arrives in the same cycle.
- PRESENT→REQ after a handoff.
- PRESENT→IDLE after a handoff with a pause pending, or on an abort.
- FLUSH→IDLE when the discarded response arrives.

Top module: `trb_ring_fetcher`

## Requirements
- R1: After reset the engine is idle: `mem_req_valid` and `out_valid` are 0 and `ring_ctl_rdata` reads 0.
- R2: A doorbell while idle issues a read at the current ring pointer. The pointer loaded from a register write is wdata bits 63:6 with the address bits 5:0 zero. The request is held with a stable address until it is accepted.
- R3: The cycle bit is bit 0 of control word 3, which is data bit 96. When it differs from the consumer cycle state, nothing is presented and the engine goes idle with pointer and cycle state unchanged. The next doorbell re-reads the same address.
- R4: An owned TRB that is not a link is presented unchanged on `out_trb` and held until accepted. After acceptance the pointer advances by 16 bytes.
- R5: `out_last_td` is 1 exactly when the chain flag of the presented TRB is clear. The chain flag is control bit 4, which is data bit 100.
- R6: A Link TRB has type 6 in control bits 15:10, which are data bits 111:106. It is never presented. The next read goes to the address in data bits 63:0 with bits 3:0 cleared. Its toggle flag is control bit 1, data bit 97. When the flag is set, the consumer cycle state is inverted.
- R7: A register write loads the ring pointer and the cycle state (wdata bit 0) only while the engine is not running. A read returns zero in bits 63:6 and 2:0, the running status in bit 3, and in bits 5:4 the value last written there.
- R8: Writing 1 to bit 1 while running stops the engine after the next TRB handoff. Later TRBs stay in memory for the next doorbell.
- R9: Writing 1 to bit 2 while running stops the engine at once. From the next cycle no TRB is presented and no read is requested. A read already issued has its response discarded. A TRB that was presented but not accepted is fetched again after the next doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_ctl_wr | input | 1 | Ring control register write strobe |
| ring_ctl_wdata | input | 64 | Write data: pointer 63:6, reserved 5:4, abort 2, pause 1, cycle 0 |
| ring_ctl_rdata | output | 64 | Read value: reserved 5:4, running 3, other bits zero |
| doorbell | input | 1 | One-cycle pulse that starts fetching |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the TRB to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Read TRB, word 0 in bits 31:0 |
| out_valid | output | 1 | Owned TRB available |
| out_ready | input | 1 | Downstream accepts the TRB |
| out_trb | output | 128 | The owned TRB |
| out_last_td | output | 1 | TRB ends its transfer descriptor |

## Verification
The hardest situation to reach is an abort while a read is in flight: the request has been accepted but its response has not yet arrived. That response must be absorbed and dropped, never presented. The bench lengthens the memory latency to six cycles and waits for the request handshake. It writes the abort in that window and watches that the output stays silent. After a fresh doorbell it checks that the stream resumes at the entry that was dropped. A pointer write during a run is also hard to observe. The bench aims it at a blank region, where zero-filled entries would match the inverted cycle state, so a wrongly accepted write would show up as a stream of bogus TRBs.

// File: rtl/trb_fetch_pkg.sv
package trb_fetch_pkg;
    localparam int TRB_W      = 128;
    localparam int CTRL_LSB   = 96;
    localparam int CYCLE_BIT  = CTRL_LSB + 0;
    localparam int TOGGLE_BIT = CTRL_LSB + 1;
    localparam int CHAIN_BIT  = CTRL_LSB + 4;
    localparam int TYPE_LSB   = CTRL_LSB + 10;
    localparam int TYPE_W     = 6;
    localparam logic [TYPE_W-1:0] TYPE_LINK = 6'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_PRESENT,
        ST_FLUSH
    } walk_state_t;
endpackage

// File: rtl/trb_ctl_reg.sv
module trb_ctl_reg #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [63:0]       wdata,
    input  logic              running,
    output logic              load_ptr,
    output logic [ADDR_W-5:0] load_val,
    output logic              load_ccs,
    output logic              pause_req,
    output logic              abort_req,
    output logic [63:0]       rdata
);
    logic [1:0] rsvd_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsvd_q <= '0;
        else if (wr)
            rsvd_q <= wdata[5:4];
    end

    always_comb begin
        load_ptr  = wr && !running;
        load_val  = {wdata[ADDR_W-1:6], 2'b00};
        load_ccs  = wdata[0];
        pause_req = wr && wdata[1] && running;
        abort_req = wr && wdata[2] && running;
        rdata     = {58'd0, rsvd_q, running, 3'b000};
    end
endmodule

// File: rtl/trb_field_dec.sv
module trb_field_dec
    import trb_fetch_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [TRB_W-1:0]  trb,
    input  logic              ccs,
    output logic              owned,
    output logic              is_link,
    output logic              toggle,
    output logic              last_td,
    output logic [ADDR_W-5:0] link_ptr
);
    always_comb begin
        owned    = trb[CYCLE_BIT] == ccs;
        is_link  = trb[TYPE_LSB +: TYPE_W] == TYPE_LINK;
        toggle   = trb[TOGGLE_BIT];
        last_td  = !trb[CHAIN_BIT];
        link_ptr = trb[ADDR_W-1:4];
    end
endmodule

// File: rtl/trb_walker.sv
module trb_walker
    import trb_fetch_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              doorbell,
    input  logic              load_ptr,
    input  logic [ADDR_W-5:0] load_val,
    input  logic              load_ccs,
    input  logic              pause_req,
    input  logic              abort_req,
    output logic              running,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [TRB_W-1:0]  mem_rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TRB_W-1:0]  out_trb,
    output logic              out_last_td
);
    localparam int PW = ADDR_W - 4;

    walk_state_t      state_q, state_d;
    logic [PW-1:0]    ptr_q, ptr_d;
    logic             ccs_q, ccs_d;
    logic             pause_q, pause_d;
    logic             hold_d;
    logic [TRB_W-1:0] trb_q;
    logic             last_q;

    logic          rsp_owned, rsp_link, rsp_toggle, rsp_last;
    logic [PW-1:0] rsp_link_ptr;

    trb_field_dec #(.ADDR_W(ADDR_W)) i_dec (
        .trb      (mem_rsp_data),
        .ccs      (ccs_q),
        .owned    (rsp_owned),
        .is_link  (rsp_link),
        .toggle   (rsp_toggle),
        .last_td  (rsp_last),
        .link_ptr (rsp_link_ptr)
    );

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        ccs_d   = ccs_q;
        pause_d = pause_q || pause_req;
        hold_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_ptr) begin
                    ptr_d = load_val;
                    ccs_d = load_ccs;
                end
                if (doorbell)
                    state_d = ST_REQ;
            end
            ST_REQ: begin
                if (mem_req_ready)
                    state_d = abort_req ? ST_FLUSH : ST_WAIT;
                else if (abort_req)
                    state_d = ST_IDLE;
            end
            ST_WAIT: begin
                if (abort_req) begin
                    state_d = mem_rsp_valid ? ST_IDLE : ST_FLUSH;
                end else if (mem_rsp_valid) begin
                    if (!rsp_owned) begin
                        state_d = ST_IDLE;
                    end else if (rsp_link) begin
                        ptr_d   = rsp_link_ptr;
                        ccs_d   = ccs_q ^ rsp_toggle;
                        state_d = ST_REQ;
                    end else begin
                        hold_d  = 1'b1;
                        state_d = ST_PRESENT;
                    end
                end
            end
            ST_PRESENT: begin
                if (abort_req) begin
                    state_d = ST_IDLE;
                end else if (out_ready) begin
                    ptr_d   = ptr_q + PW'(1);
                    state_d = pause_d ? ST_IDLE : ST_REQ;
                end
            end
            ST_FLUSH: begin
                if (mem_rsp_valid)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_d == ST_IDLE)
            pause_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            ccs_q   <= 1'b0;
            pause_q <= 1'b0;
            trb_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            ccs_q   <= ccs_d;
            pause_q <= pause_d;
            if (hold_d) begin
                trb_q  <= mem_rsp_data;
                last_q <= rsp_last;
            end
        end
    end

    always_comb begin
        running       = state_q != ST_IDLE;
        mem_req_valid = state_q == ST_REQ;
        mem_req_addr  = {ptr_q, 4'b0000};
        out_valid     = state_q == ST_PRESENT;
        out_trb       = trb_q;
        out_last_td   = last_q;
    end

    // R2: request stays up with a fixed address until taken
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready && !abort_req |=> mem_req_valid && $stable(mem_req_addr));

    // R3: an idle engine keeps its place unless software reloads it
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && !load_ptr |=> $stable(ptr_q) && $stable(ccs_q));

    // R3: only entries whose cycle bit matches are presented
    p_owned_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_trb[CYCLE_BIT] == ccs_q);

    // R4: presented entry holds until accepted
    p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !abort_req |=> out_valid && $stable(out_trb) && $stable(out_last_td));

    // R6: links never reach the stream
    p_no_link_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_trb[TYPE_LSB +: TYPE_W] != TYPE_LINK);

    // R9: abort silences both sides on the next cycle
    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !out_valid && !mem_req_valid);
endmodule

// File: rtl/trb_ring_fetcher.sv
module trb_ring_fetcher
    import trb_fetch_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_ctl_wr,
    input  logic [63:0]       ring_ctl_wdata,
    output logic [63:0]       ring_ctl_rdata,
    input  logic              doorbell,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [127:0]      mem_rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [127:0]      out_trb,
    output logic              out_last_td
);
    logic              running, load_ptr, load_ccs, pause_req, abort_req;
    logic [ADDR_W-5:0] load_val;

    trb_ctl_reg #(.ADDR_W(ADDR_W)) i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ring_ctl_wr),
        .wdata     (ring_ctl_wdata),
        .running   (running),
        .load_ptr  (load_ptr),
        .load_val  (load_val),
        .load_ccs  (load_ccs),
        .pause_req (pause_req),
        .abort_req (abort_req),
        .rdata     (ring_ctl_rdata)
    );

    trb_walker #(.ADDR_W(ADDR_W)) i_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .doorbell      (doorbell),
        .load_ptr      (load_ptr),
        .load_val      (load_val),
        .load_ccs      (load_ccs),
        .pause_req     (pause_req),
        .abort_req     (abort_req),
        .running       (running),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_trb       (out_trb),
        .out_last_td   (out_last_td)
    );

    // R7: the running bit follows the walker and no pointer bits leak out
    p_rdata_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ring_ctl_rdata[3] == (out_valid || mem_req_valid || running) && ring_ctl_rdata[63:6] == '0);
endmodule

// File: tb/test_trb_ring_fetcher.sv
module test_trb_ring_fetcher;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ring_ctl_wr = 1'b0;
    logic [63:0]  ring_ctl_wdata = '0;
    logic [63:0]  ring_ctl_rdata;
    logic         doorbell = 1'b0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [63:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_trb;
    logic         out_last_td;

    trb_ring_fetcher #(.ADDR_W(64)) i_trb_ring_fetcher (
        .clk(clk), .rst_n(rst_n),
        .ring_ctl_wr(ring_ctl_wr), .ring_ctl_wdata(ring_ctl_wdata), .ring_ctl_rdata(ring_ctl_rdata),
        .doorbell(doorbell),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_trb(out_trb), .out_last_td(out_last_td)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int out_mode = 1;
    int lat = 2;
    int handoffs = 0;
    int req_count = 0;
    bit quiet = 1'b0;
    bit capture_first = 1'b0;
    longint unsigned first_addr = 0;

    logic [127:0] mem [longint unsigned];
    logic [128:0] exp_q [$];
    longint unsigned pend_addr [$];
    int pend_due [$];

    function automatic logic [127:0] rd(longint unsigned a);
        return mem.exists(a >> 4) ? mem[a >> 4] : 128'd0;
    endfunction

    function automatic logic [127:0] mk_trb(int id, bit cy, bit chain);
        logic [31:0] ctrl;
        ctrl = 32'd0;
        ctrl[15:10] = 6'd1;
        ctrl[4] = chain;
        ctrl[0] = cy;
        return {ctrl, 32'(id * 3 + 7), ~32'(id), 32'hA500_0000 | 32'(id)};
    endfunction

    function automatic logic [127:0] mk_link(longint unsigned tgt, bit cy, bit tog);
        logic [31:0] ctrl;
        ctrl = 32'd0;
        ctrl[15:10] = 6'd6;
        ctrl[1] = tog;
        ctrl[0] = cy;
        return {ctrl, 32'd0, tgt};
    endfunction

    // Behavioural walk of the ring: fills the expected queue, updates position
    task automatic model_walk(inout longint unsigned p, inout bit c);
        for (int n = 0; n < 200; n++) begin
            logic [127:0] t;
            t = rd(p);
            if (t[96] != c) break;
            if (t[111:106] == 6'd6) begin
                p = {t[63:4], 4'b0};
                if (t[97]) c = ~c;
            end else begin
                exp_q.push_back({!t[100], t});
                p = p + 16;
            end
        end
    endtask

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Per-clock driver and comparator, runs just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            cyc++;
            if (cyc > 20000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
                finish_run();
            end
            mem_req_ready = (cyc % 4) != 1;
            out_ready = (out_mode == 1) || (out_mode == 2 && (cyc % 3) != 0);
            mem_rsp_valid = 1'b0;
            if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = rd(pend_addr[0]);
                void'(pend_addr.pop_front());
                void'(pend_due.pop_front());
            end
            if (mem_req_valid && mem_req_ready) begin
                req_count++;
                if (capture_first) begin
                    first_addr = mem_req_addr;
                    capture_first = 1'b0;
                end
                pend_addr.push_back(mem_req_addr);
                pend_due.push_back(cyc + lat);
            end
            if (quiet)
                chk(!out_valid, "R9", "output while aborted", 128'(out_valid), 128'd0);
            if (out_valid && out_ready) begin
                handoffs++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected TRB", out_trb, 128'd0);
                end else begin
                    logic [128:0] e;
                    e = exp_q.pop_front();
                    chk(out_trb == e[127:0], "R4", "TRB data", out_trb, e[127:0]);
                    chk(out_last_td == e[128], "R5", "last-TD flag", 128'(out_last_td), 128'(e[128]));
                end
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic ctl_write(logic [63:0] v);
        ring_ctl_wdata = v;
        ring_ctl_wr = 1'b1;
        step();
        ring_ctl_wr = 1'b0;
    endtask

    task automatic ring_bell();
        doorbell = 1'b1;
        step();
        doorbell = 1'b0;
    endtask

    task automatic wait_idle();
        step(3);
        for (int n = 0; n < 2000 && ring_ctl_rdata[3]; n++) step();
        step(2);
    endtask

    longint unsigned mp;
    bit mc;
    int h0, r0;

    initial begin
        step(5);
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk(!mem_req_valid && !out_valid, "R1", "idle outputs", 128'({mem_req_valid, out_valid}), 128'd0);
        chk(ring_ctl_rdata == 64'd0, "R1", "register read", 128'(ring_ctl_rdata), 128'd0);

        // R7: load while idle, reserved bits return, pointer reads zero
        ctl_write(64'h1000 | 64'h21);
        chk(ring_ctl_rdata == 64'h20, "R7", "read after load", 128'(ring_ctl_rdata), 128'h20);

        // Two segments, the second link toggles back to the first
        for (int i = 0; i < 5; i++) mem[(64'h1000 >> 4) + i] = mk_trb(i, 1'b1, (i == 0 || i == 1 || i == 3));
        mem[(64'h1000 >> 4) + 5] = mk_link(64'h2000, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) mem[(64'h2000 >> 4) + i] = mk_trb(10 + i, 1'b1, (i == 1));
        mem[(64'h2000 >> 4) + 3] = mk_link(64'h1000, 1'b1, 1'b1);
        mp = 64'h1000; mc = 1'b1;
        model_walk(mp, mc);
        h0 = handoffs;
        capture_first = 1'b1;
        ring_bell();
        wait_idle();
        chk(first_addr == 64'h1000, "R2", "first read address", 128'(first_addr), 128'h1000);
        chk(handoffs - h0 == 8, "R6", "TRBs without links", 128'(handoffs - h0), 128'd8);
        chk(mp == 64'h1000 && mc == 1'b0, "R6", "model end state", 128'(mp), 128'h1000);

        // R3/R6: producer refills with cycle 0 after the toggle, stream under stalls
        mem[(64'h1000 >> 4) + 0] = mk_trb(20, 1'b0, 1'b1);
        mem[(64'h1000 >> 4) + 1] = mk_trb(21, 1'b0, 1'b0);
        model_walk(mp, mc);
        out_mode = 2;
        h0 = handoffs;
        ring_bell();
        wait_idle();
        chk(handoffs - h0 == 2, "R3", "refill count", 128'(handoffs - h0), 128'd2);

        // R3: immediate mismatch, place held
        h0 = handoffs;
        capture_first = 1'b1;
        ring_bell();
        wait_idle();
        chk(handoffs == h0, "R3", "no output on mismatch", 128'(handoffs - h0), 128'd0);
        chk(first_addr == 64'h1020, "R3", "re-read address", 128'(first_addr), 128'h1020);
        chk(exp_q.size() == 0, "R4", "stream complete", 128'(exp_q.size()), 128'd0);

        // Long ring for pause and abort
        for (int i = 0; i < 12; i++) mem[(64'h4000 >> 4) + i] = mk_trb(40 + i, 1'b1, (i % 3) != 2);
        mem[(64'h4000 >> 4) + 12] = mk_link(64'h4000, 1'b1, 1'b1);
        ctl_write(64'h4001);
        mp = 64'h4000; mc = 1'b1;
        model_walk(mp, mc);
        out_mode = 0;
        ring_bell();
        for (int n = 0; n < 100 && !out_valid; n++) step();
        chk(ring_ctl_rdata[3] == 1'b1, "R7", "running bit", 128'(ring_ctl_rdata[3]), 128'd1);
        ctl_write(64'h9000);           // R7: ignored while running
        // R8: pause, then release one handoff
        h0 = handoffs;
        ctl_write(64'h2);
        out_mode = 1;
        wait_idle();
        chk(handoffs - h0 == 1, "R8", "one handoff after pause", 128'(handoffs - h0), 128'd1);

        // R9: abort with a TRB held on the output
        out_mode = 0;
        ring_bell();
        for (int n = 0; n < 100 && !out_valid; n++) step();
        h0 = handoffs;
        ctl_write(64'h4);
        quiet = 1'b1;
        chk(!out_valid, "R9", "valid dropped", 128'(out_valid), 128'd0);
        wait_idle();
        quiet = 1'b0;
        chk(handoffs == h0, "R9", "nothing handed", 128'(handoffs - h0), 128'd0);

        // R9: abort with a read in flight
        lat = 6;
        out_mode = 1;
        r0 = req_count;
        ring_bell();
        for (int n = 0; n < 100 && req_count == r0; n++) step();
        ctl_write(64'h4);
        quiet = 1'b1;
        step(12);
        wait_idle();
        quiet = 1'b0;
        chk(handoffs == h0, "R9", "in-flight response dropped", 128'(handoffs - h0), 128'd0);

        // Resume: the rest of the stream, starting at the dropped entry
        lat = 2;
        out_mode = 2;
        ring_bell();
        wait_idle();
        chk(exp_q.size() == 0, "R8", "resumed stream complete", 128'(exp_q.size()), 128'd0);
        chk(handoffs - h0 == 11, "R9", "refetched count", 128'(handoffs - h0), 128'd11);
        finish_run();
    end
endmodule